// File: doc/BRIEF.md
# Duty-Cycle Adjust Code Search Engine

This block calibrates one duty-cycle correction lane. It steps a 7-bit adjust code while it watches a single-bit comparator. The comparator reads 1 when the corrected clock sits above 50% duty, which means the code must come down. It reads 0 when the duty sits below 50%, which means the code must go up. A start pulse loads a seed code. The engine then runs the search twice, first on side A and then on side B, and side B starts from a seed taken from side A's outcome. At the end it merges the two side results into one final code and writes that code back to the lane.

Each time the engine writes the lane it updates a 10-bit lane control word and pulses a write strobe. After every new code it holds the code for a fixed settle time, then samples the comparator, then holds for the same time again before it takes the next step. Calibration never reports an overall failure. A side that cannot find its transition only raises its own fail flag, and the merge falls back to whatever results remain.

Top module: `dcc_code_search`

## Requirements
- R1: After reset, `lane_wr_o`, `done_o`, `fail_a_o` and `fail_b_o` are 0, `result_o` is 0, and the lane word is all zeros.
- R2: A start accepted while idle writes the lane on the next edge. The write carries the seed in code bits [6:0], the correction-enable bit [9] set to 1, and the side-select bit [8] set to 1, which selects side A.
- R3: On every lane write, bit [7] of the lane word (the comparator-output field) is 0.
- R4: The first comparator sample of a side sets its direction. A 0 makes the engine step the code up by one per step until a sample reads 1. A 1 makes it step down by one until a sample reads 0. The code under the first matching sample becomes that side's result.
- R5: When a sample does not match and the code already sits at 127 while stepping up, or at 0 while stepping down, that side fails. Its fail flag (`fail_a_o` or `fail_b_o`) is then 1 when done is reported.
- R6: WAIT_CYC is ceil(WAIT_NS*1000/CLK_PERIOD_PS). The comparator is sampled WAIT_CYC cycles after each code is written, and the next step is written WAIT_CYC cycles later. Within a side, successive lane writes are therefore exactly 2*WAIT_CYC cycles apart, and the code does not change between writes.
- R7: Side B starts with side-select 0. Its first code is side A's result minus one when side A passed with a non-zero result. Otherwise it is the original seed.
- R8: The final code is chosen as follows:
  - if both sides passed, it is floor((A+B)/2);
  - if only one side passed, it is that side's value;
  - if neither side passed, it is the original seed.
- R9: When the final code is written, correction-enable is 0, the code equals `result_o`, and `done_o` is high for exactly one cycle. `result_o` changes only on that done cycle. Both fail flags clear when the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only while idle |
| seed_i | input | CODE_W | Seed adjust code |
| cmp_i | input | 1 | Duty comparator: 1 means above 50% |
| lane_ctl_o | output | CODE_W+3 | Lane word {corr_en, side_sel, cmp_field, code} |
| lane_wr_o | output | 1 | Lane write strobe |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | CODE_W | Final merged code |
| fail_a_o | output | 1 | Side A search failed |
| fail_b_o | output | 1 | Side B search failed |

## Verification
The bench keeps CODE_W at 7, so both overrun limits at 127 and 0 fall inside the sweep. It sets CLK_PERIOD_PS=8000 and WAIT_NS=16, which gives a two-cycle settle. With that short settle, even a full 127-step walk on each side finishes in about a thousand cycles, and the whole sweep fits in the run. The sweep crosses seeds at both ends and in the middle with per-side comparator thresholds. The thresholds include values that are never reached in either direction, which drives every merge fallback and the side-B reseed path.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_HOLD   = 2'd2
  } search_st_e;

  // True when a further step in the chosen direction would leave the code range
  function automatic bit f_at_limit(int unsigned code, bit up, int unsigned max_code);
    return up ? (code == max_code) : (code == 0);
  endfunction

  // Starting code for the second side
  function automatic int unsigned f_seed_b(bit pass_a, int unsigned res_a, int unsigned seed);
    return (pass_a && res_a != 0) ? res_a - 1 : seed;
  endfunction

  // Combine the two side outcomes into the final code
  function automatic int unsigned f_merge(bit pass_a, int unsigned res_a,
                                          bit pass_b, int unsigned res_b,
                                          int unsigned seed);
    if (pass_a && pass_b) return (res_a + res_b) >> 1;
    if (pass_a)           return res_a;
    if (pass_b)           return res_b;
    return seed;
  endfunction

endpackage

// File: rtl/dcc_wait_timer.sv
module dcc_wait_timer #(
  parameter int unsigned WAIT_CYC = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dcc_side_merge.sv
module dcc_side_merge
  import dcc_pkg::*;
#(
  parameter int unsigned CODE_W = 7
) (
  input  logic              pass_a_i,
  input  logic [CODE_W-1:0] res_a_i,
  input  logic              pass_b_i,
  input  logic [CODE_W-1:0] res_b_i,
  input  logic [CODE_W-1:0] seed_i,
  output logic [CODE_W-1:0] seed_b_o,
  output logic [CODE_W-1:0] final_o
);
  assign seed_b_o = CODE_W'(f_seed_b(pass_a_i, 32'(res_a_i), 32'(seed_i)));
  assign final_o  = CODE_W'(f_merge(pass_a_i, 32'(res_a_i), pass_b_i, 32'(res_b_i),
                                    32'(seed_i)));
endmodule

// File: rtl/dcc_code_search.sv
module dcc_code_search
  import dcc_pkg::*;
#(
  parameter int unsigned CODE_W        = 7,
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned WAIT_NS       = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CODE_W-1:0] seed_i,
  input  logic              cmp_i,
  output logic [CODE_W+2:0] lane_ctl_o,
  output logic              lane_wr_o,
  output logic              done_o,
  output logic [CODE_W-1:0] result_o,
  output logic              fail_a_o,
  output logic              fail_b_o
);
  localparam int unsigned WAIT_RAW = (WAIT_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int unsigned WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
  localparam int unsigned MAX_CODE = (1 << CODE_W) - 1;

  search_st_e        st_q;
  logic [CODE_W-1:0] code_q, seed_q, res_a_q, result_q;
  logic              side_a_q, corr_en_q, wr_q, up_q, first_q, pass_a_q;
  logic              done_q, fail_a_q, fail_b_q;

  // Named internal events
  logic tick, start_acc, sample_evt, up_now, hit, at_lim, side_end;
  logic              m_pass_a;
  logic [CODE_W-1:0] m_res_a, seed_b, final_code;

  dcc_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st_q != ST_IDLE),
    .tick_o (tick)
  );

  assign start_acc  = (st_q == ST_IDLE) && start_i;
  assign sample_evt = (st_q == ST_SETTLE) && tick;
  assign up_now     = first_q ? !cmp_i : up_q;
  assign hit        = !first_q && (cmp_i == up_q);
  assign at_lim     = f_at_limit(32'(code_q), up_now, MAX_CODE);
  assign side_end   = sample_evt && (hit || at_lim);

  assign m_pass_a = side_a_q ? hit    : pass_a_q;
  assign m_res_a  = side_a_q ? code_q : res_a_q;

  dcc_side_merge #(.CODE_W(CODE_W)) u_merge (
    .pass_a_i (m_pass_a),
    .res_a_i  (m_res_a),
    .pass_b_i (hit),
    .res_b_i  (code_q),
    .seed_i   (seed_q),
    .seed_b_o (seed_b),
    .final_o  (final_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      code_q    <= '0;
      seed_q    <= '0;
      res_a_q   <= '0;
      result_q  <= '0;
      side_a_q  <= 1'b0;
      corr_en_q <= 1'b0;
      wr_q      <= 1'b0;
      up_q      <= 1'b0;
      first_q   <= 1'b0;
      pass_a_q  <= 1'b0;
      done_q    <= 1'b0;
      fail_a_q  <= 1'b0;
      fail_b_q  <= 1'b0;
    end else begin
      wr_q   <= 1'b0;
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            seed_q    <= seed_i;
            code_q    <= seed_i;
            side_a_q  <= 1'b1;
            corr_en_q <= 1'b1;
            first_q   <= 1'b1;
            fail_a_q  <= 1'b0;
            fail_b_q  <= 1'b0;
            wr_q      <= 1'b1;
            st_q      <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (sample_evt) begin
            first_q <= 1'b0;
            up_q    <= up_now;
            if (side_end && side_a_q) begin
              pass_a_q <= hit;
              res_a_q  <= code_q;
              fail_a_q <= !hit;
              code_q   <= seed_b;
              side_a_q <= 1'b0;
              first_q  <= 1'b1;
              wr_q     <= 1'b1;
            end else if (side_end) begin
              fail_b_q  <= !hit;
              code_q    <= final_code;
              result_q  <= final_code;
              corr_en_q <= 1'b0;
              wr_q      <= 1'b1;
              done_q    <= 1'b1;
              st_q      <= ST_IDLE;
            end else begin
              st_q <= ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (tick) begin
            code_q <= up_q ? code_q + 1'b1 : code_q - 1'b1;
            wr_q   <= 1'b1;
            st_q   <= ST_SETTLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // Comparator-output field is always written as zero
  assign lane_ctl_o = {corr_en_q, side_a_q, 1'b0, code_q};
  assign lane_wr_o  = wr_q;
  assign done_o     = done_q;
  assign result_o   = result_q;
  assign fail_a_o   = fail_a_q;
  assign fail_b_o   = fail_b_q;
endmodule

// File: rtl/dcc_code_search_chk.sv
module dcc_code_search_chk #(
  parameter int unsigned CODE_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_acc,
  input logic              lane_wr,
  input logic              corr_en,
  input logic              side_a,
  input logic [CODE_W-1:0] code,
  input logic              done,
  input logic [CODE_W-1:0] result,
  input logic              fail_a,
  input logic              fail_b
);
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !done);

  p_final_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> (lane_wr && !corr_en && code == result));

  p_result_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |-> $stable(result));

  p_flags_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_acc |=> (!fail_a && !fail_b));

  p_code_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lane_wr |-> $stable(code));

  p_unit_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_wr && corr_en && $past(corr_en) && side_a == $past(side_a))
      |-> (code == $past(code) + 1'b1 || code == $past(code) - 1'b1));
endmodule

bind dcc_code_search dcc_code_search_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_acc (start_acc),
  .lane_wr   (wr_q),
  .corr_en   (corr_en_q),
  .side_a    (side_a_q),
  .code      (code_q),
  .done      (done_q),
  .result    (result_q),
  .fail_a    (fail_a_q),
  .fail_b    (fail_b_q)
);

// File: tb/test_dcc_code_search.sv
module test_dcc_code_search;
  localparam int CW   = 7;
  localparam int WCYC = 2;   // ceil(16 ns / 8 ns)

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] seed = '0;
  logic          cmp;
  logic [CW+2:0] lane;
  logic          wr, done, fa, fb;
  logic [CW-1:0] result;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int thr_a = 0;
  int thr_b = 0;

  always #4ns clk = ~clk;

  // Comparator model: reads 1 once the code reaches the side's threshold
  assign cmp = lane[8] ? (int'(lane[6:0]) >= thr_a) : (int'(lane[6:0]) >= thr_b);

  dcc_code_search #(.CODE_W(CW), .CLK_PERIOD_PS(8000), .WAIT_NS(16)) i_dcc_code_search (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .seed_i(seed), .cmp_i(cmp),
    .lane_ctl_o(lane), .lane_wr_o(wr), .done_o(done), .result_o(result),
    .fail_a_o(fa), .fail_b_o(fb)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      failures++;
      $display("FAIL watchdog: run did not end, actual cyc=%0d expected < 190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Side outcome from threshold arithmetic
  function automatic void side_model(int s, int t, output bit pass, output int res);
    pass = 1'b0;
    res  = 0;
    if (s < t) begin
      if (t <= 127) begin pass = 1'b1; res = t; end
    end else begin
      if (t >= 1) begin pass = 1'b1; res = t - 1; end
    end
  endfunction

  task automatic run_case(int s, int ta, int tb);
    bit pa, pb;
    int ra, rb, sb, fin, prev_result;
    int writes = 0, last_wr = 0, prev_side = 1, done_cnt = 0;
    bit cmp_bad = 0, gap_bad = 0, start_bad = 0, sb_bad = 0, fin_bad = 0;
    bit flag_clr_bad = 0, hold_bad = 0, finished = 0;
    int guard = 0;
    side_model(s, ta, pa, ra);
    sb = (pa && ra > 0) ? ra - 1 : s;
    side_model(sb, tb, pb, rb);
    if (pa && pb)  fin = (ra + rb) / 2;
    else if (pa)   fin = ra;
    else if (pb)   fin = rb;
    else           fin = s;

    thr_a = ta;
    thr_b = tb;
    prev_result = int'(result);
    seed  = CW'(s);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!finished && guard < 5000) begin
      guard++;
      if (wr) begin
        writes++;
        if (lane[7] !== 1'b0) cmp_bad = 1;
        if (writes == 1) begin
          if (!(lane[9] && lane[8] && int'(lane[6:0]) == s)) start_bad = 1;
          if (fa || fb) flag_clr_bad = 1;
          if (int'(result) != prev_result) hold_bad = 1;
        end else if (lane[9]) begin
          if (prev_side == 1 && lane[8] == 1'b0) begin
            if (int'(lane[6:0]) != sb) sb_bad = 1;
          end else if (cyc - last_wr != 2 * WCYC) gap_bad = 1;
        end
        last_wr   = cyc;
        prev_side = int'(lane[8]);
      end else if (writes > 1 && !done && int'(result) != prev_result) hold_bad = 1;
      if (done) begin
        done_cnt++;
        if (!(wr && !lane[9] && int'(lane[6:0]) == fin)) fin_bad = 1;
        @(negedge clk);
        if (done) done_cnt++;
        finished = 1;
      end else @(negedge clk);
    end
    chk(finished,      "R9 done reached",            int'(finished), 1);
    chk(done_cnt == 1, "R9 done width",              done_cnt, 1);
    chk(!fin_bad,      "R9 final write",             int'(lane[6:0]), fin);
    chk(!flag_clr_bad, "R9 flags cleared at start",  int'(flag_clr_bad), 0);
    chk(!hold_bad,     "R9 result held",             int'(hold_bad), 0);
    chk(!start_bad,    "R2 first write",             s, s);
    chk(!cmp_bad,      "R3 cmp field zero",          int'(cmp_bad), 0);
    chk(!gap_bad,      "R6 write spacing",           int'(gap_bad), 0);
    chk(!sb_bad,       "R7 side B seed",             int'(sb_bad), 0);
    chk(int'(fa) == int'(!pa), "R5 side A fail flag", int'(fa), int'(!pa));
    chk(int'(fb) == int'(!pb), "R5 side B fail flag", int'(fb), int'(!pb));
    chk(int'(result) == fin,   "R4 R8 final code",    int'(result), fin);
  endtask

  initial begin
    int seeds[4] = '{0, 20, 64, 127};
    int thrs[6]  = '{0, 1, 50, 100, 127, 128};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(wr == 1'b0 && done == 1'b0, "R1 strobes idle", int'(wr) + int'(done), 0);
    chk(fa == 1'b0 && fb == 1'b0,   "R1 flags idle",   int'(fa) + int'(fb), 0);
    chk(result == '0 && lane == '0, "R1 outputs zero", int'(lane), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    foreach (seeds[i])
      foreach (thrs[j])
        foreach (thrs[k]) begin
          if (seeds[i] == 64 || j == k || k == 2)
            run_case(seeds[i], thrs[j], thrs[k]);
          repeat (2) @(negedge clk);
        end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule